// File: doc/BRIEF.md
# FIFO Interrupt Flag Controller

This block keeps the interrupt state of a FIFO-based serial controller. The datapath reports activity as single-cycle strobes and as the current occupancy of its transmit and receive FIFOs. From these the block derives six sticky event flags and two live level flags, and holds an enable mask and two occupancy thresholds. It drives one interrupt line.

Software reaches the block through a simple 32-bit register port. A write strobe, a 2-bit write address and write data update the registers. A separate 2-bit read address returns read data combinationally. Address 0 is the status register. Address 1 is the enable register and uses the same bit layout. Address 2 holds the two thresholds. Sticky flags stay set until software writes a 1 to their bit position in the status register.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every sticky flag, the enable mask, both thresholds and `irq`. After reset, with both occupancies at zero, the status register therefore reads 0x0000_0005.
- R2: Status and enable share one bit layout: TX level at bit 0, TX empty at bit 1, RX level at bit 2, RX full at bit 3, transfer done at bit 11, TX overrun at bit 12, RX overrun at bit 14 and RX underrun at bit 15. All other bits read as zero, and the enable register keeps only the bits in this layout. The address map is: 0 for status, 1 for enable, 2 for thresholds. `rd_data` follows `rd_addr` in the same cycle.
- R3: Address 2 holds the TX threshold in bits 4:0 and the RX threshold in bits 20:16. The TX level bit reads 1 exactly when `tx_count` is at or above the TX threshold. The RX level bit reads 1 exactly when `rx_count` is at or above the RX threshold. Writing to either level bit has no effect.
- R4: Writing the status register clears each sticky flag whose bit in the written data is 1. Flags whose bit is 0 are left unchanged.
- R5: When an event and a write-one clear of the same flag fall in the same cycle, the flag stays set.
- R6: An `rx_push` while `rx_count` is DEPTH-1 (31) sets RX full. An `rx_push` while `rx_count` is DEPTH (32) sets RX overrun and does not set RX full. An `rx_push` at any lower count sets neither flag.
- R7: An `rx_read` while `rx_count` is 0 sets RX underrun. An `rx_read` at a nonzero count does not set it.
- R8: A `tx_push` while `tx_count` is DEPTH (32) sets TX overrun. A `tx_push` at a lower count does not set it.
- R9: A `tx_start` strobe sets TX empty, and an `xfer_done` strobe sets transfer done.
- R10: `irq` is a register that holds the OR, over all eight flags including the level flags, of flag AND enable. It follows any change in a flag or an enable one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| tx_push | input | 1 | A byte is offered to the TX FIFO |
| tx_start | input | 1 | A start command drained the queued TX bytes |
| xfer_done | input | 1 | The transfer has finished |
| rx_push | input | 1 | A byte arrives for the RX FIFO |
| rx_read | input | 1 | Software read of the data register |
| tx_count | input | 6 | TX FIFO occupancy, 0 to DEPTH |
| rx_count | input | 6 | RX FIFO occupancy, 0 to DEPTH |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that `tx_count` and `rx_count` never exceed DEPTH. They also assume that each strobe reports the occupancy as it was before the strobe's own effect, so a push at a count of 32 is an overflow attempt and not a successful enqueue. The stimulus sets the counts directly within 0 to 32 and holds them steady around each strobe. Event strobes last a single cycle. The thresholds stay at 31 during the event tests, so the level bits are known while the sticky flags are checked.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int REG_W        = 32;
    localparam int NUM_STICKY   = 6;

    localparam int POS_TX_LVL   = 0;
    localparam int POS_TX_EMPTY = 1;
    localparam int POS_RX_LVL   = 2;
    localparam int POS_RX_FULL  = 3;
    localparam int POS_DONE     = 11;
    localparam int POS_TX_OVR   = 12;
    localparam int POS_RX_OVR   = 14;
    localparam int POS_RX_UND   = 15;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (32'd1 << POS_TX_LVL)  | (32'd1 << POS_TX_EMPTY) |
        (32'd1 << POS_RX_LVL)  | (32'd1 << POS_RX_FULL)  |
        (32'd1 << POS_DONE)    | (32'd1 << POS_TX_OVR)   |
        (32'd1 << POS_RX_OVR)  | (32'd1 << POS_RX_UND);

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_THRESH = 2'd2
    } reg_addr_e;

    // Index 0 is the least significant member (tx_empty).
    typedef struct packed {
        logic rx_und;
        logic rx_ovr;
        logic tx_ovr;
        logic done;
        logic rx_full;
        logic tx_empty;
    } sticky_ev_t;

    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return POS_TX_EMPTY;
            1:       return POS_RX_FULL;
            2:       return POS_DONE;
            3:       return POS_TX_OVR;
            4:       return POS_RX_OVR;
            default: return POS_RX_UND;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] place_sticky(input logic [NUM_STICKY-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_STICKY; i++) r[sticky_pos(i)] = v[i];
        return r;
    endfunction

endpackage

// File: rtl/irq_event_detect.sv
module irq_event_detect
    import irq_ctrl_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             tx_push,
    input  logic             tx_start,
    input  logic             xfer_done,
    input  logic             rx_push,
    input  logic             rx_read,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output sticky_ev_t       ev
);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    always_comb begin
        ev          = '0;
        ev.tx_empty = tx_start;
        ev.done     = xfer_done;
        ev.rx_full  = rx_push && (rx_count == LAST_SLOT);
        ev.rx_ovr   = rx_push && (rx_count == FULL_CNT);
        ev.rx_und   = rx_read && (rx_count == '0);
        ev.tx_ovr   = tx_push && (tx_count == FULL_CNT);
    end
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
    parameter int N     = 2,
    parameter int CNT_W = 6,
    parameter int THR_W = 5
) (
    input  logic [N-1:0][CNT_W-1:0] cnt,
    input  logic [N-1:0][THR_W-1:0] thr,
    output logic [N-1:0]            lvl
);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lvl[g] = CMP_W'(cnt[g]) >= CMP_W'(thr[g]);
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flag[g] <= 1'b0;
            else if (set[g]) flag[g] <= 1'b1;
            else if (clr[g]) flag[g] <= 1'b0;
        end

        a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !set[g]) |=> !flag[g]);
        a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> flag[g]);
    end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int THR_W = 5,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             tx_push,
    input  logic             tx_start,
    input  logic             xfer_done,
    input  logic             rx_push,
    input  logic             rx_read,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             irq
);
    localparam int RX_THR_LSB = 16;

    sticky_ev_t              ev;
    logic [NUM_STICKY-1:0]   clr_vec;
    logic [NUM_STICKY-1:0]   sticky_q;
    logic [1:0]              lvl;
    logic [1:0][CNT_W-1:0]   cnt_pair;
    logic [1:0][THR_W-1:0]   thr_pair;
    logic [THR_W-1:0]        tx_thr_q, rx_thr_q;
    logic [REG_W-1:0]        en_q;
    logic [REG_W-1:0]        status;
    reg_addr_e               wa, ra;

    assign wa = reg_addr_e'(wr_addr);
    assign ra = reg_addr_e'(rd_addr);

    irq_event_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_detect (
        .tx_push  (tx_push),
        .tx_start (tx_start),
        .xfer_done(xfer_done),
        .rx_push  (rx_push),
        .rx_read  (rx_read),
        .tx_count (tx_count),
        .rx_count (rx_count),
        .ev       (ev)
    );

    always_comb begin
        for (int i = 0; i < NUM_STICKY; i++)
            clr_vec[i] = wr_en && (wa == ADDR_STATUS) && wr_data[sticky_pos(i)];
    end

    irq_flag_bank #(.N(NUM_STICKY)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (ev),
        .clr (clr_vec),
        .flag(sticky_q)
    );

    assign cnt_pair = {rx_count, tx_count};
    assign thr_pair = {rx_thr_q, tx_thr_q};

    irq_level_cmp #(.N(2), .CNT_W(CNT_W), .THR_W(THR_W)) u_level (
        .cnt(cnt_pair),
        .thr(thr_pair),
        .lvl(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else if (wr_en) begin
            if (wa == ADDR_ENABLE) en_q <= wr_data & IMPL_MASK;
            if (wa == ADDR_THRESH) begin
                tx_thr_q <= wr_data[THR_W-1:0];
                rx_thr_q <= wr_data[RX_THR_LSB +: THR_W];
            end
        end
    end

    always_comb begin
        status             = place_sticky(sticky_q);
        status[POS_TX_LVL] = lvl[0];
        status[POS_RX_LVL] = lvl[1];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & en_q);
    end

    always_comb begin
        rd_data = '0;
        case (ra)
            ADDR_STATUS: rd_data = status;
            ADDR_ENABLE: rd_data = en_q;
            ADDR_THRESH: begin
                rd_data[THR_W-1:0]           = tx_thr_q;
                rd_data[RX_THR_LSB +: THR_W] = rx_thr_q;
            end
            default:     rd_data = '0;
        endcase
    end

    a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (ra != ADDR_THRESH) |-> ((rd_data & ~IMPL_MASK) == '0));
    a_r6_overrun_at_full: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_count == CNT_W'(DEPTH)) |=> sticky_q[4]);
    a_r7_underrun_on_empty: assert property (@(posedge clk) disable iff (rst)
        (rx_read && rx_count == '0) |=> sticky_q[5]);
    a_r10_irq_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
        $past(en_q == '0) |-> !irq);
endmodule

// File: tb/fifo_irq_ctrl_tb_top.sv
module fifo_irq_ctrl_tb_top;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [1:0]       wr_addr;
    logic [31:0]      wr_data;
    logic [1:0]       rd_addr;
    logic [31:0]      rd_data;
    logic             tx_push, tx_start, xfer_done, rx_push, rx_read;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             irq;

    int checks   = 0;
    int failures = 0;
    logic [31:0] exp_sticky;
    logic [4:0]  m_tthr, m_rthr;
    logic [31:0] d;

    always #4 clk = ~clk;

    fifo_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_push(tx_push), .tx_start(tx_start),
        .xfer_done(xfer_done), .rx_push(rx_push), .rx_read(rx_read),
        .tx_count(tx_count), .rx_count(rx_count), .irq(irq)
    );

    // {tx_count, rx_count, tx_thr, rx_thr, expected {rx_lvl, tx_lvl}}
    localparam logic [23:0] VEC [6] = '{
        {6'd3,  6'd0,  5'd4,  5'd1,  2'b00},
        {6'd4,  6'd1,  5'd4,  5'd1,  2'b11},
        {6'd31, 6'd32, 5'd31, 5'd31, 2'b11},
        {6'd0,  6'd16, 5'd1,  5'd17, 2'b00},
        {6'd32, 6'd5,  5'd31, 5'd6,  2'b01},
        {6'd9,  6'd20, 5'd10, 5'd20, 2'b10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lvl_m();
        logic [31:0] r = '0;
        r[0] = tx_count >= {1'b0, m_tthr};
        r[2] = rx_count >= {1'b0, m_rthr};
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic strobe(input logic tp, input logic ts, input logic xd,
                          input logic rp, input logic rr);
        @(negedge clk);
        tx_push = tp; tx_start = ts; xfer_done = xd; rx_push = rp; rx_read = rr;
        @(negedge clk);
        tx_push = 0; tx_start = 0; xfer_done = 0; rx_push = 0; rx_read = 0;
    endtask

    task automatic chk_status(input string req);
        rd(2'd0, d);
        chk(req, d, exp_sticky | lvl_m());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        tx_push = 0; tx_start = 0; xfer_done = 0; rx_push = 0; rx_read = 0;
        tx_count = 0; rx_count = 0;
        exp_sticky = '0; m_tthr = 0; m_rthr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(2'd0, d); chk("R1 status", d, 32'h0000_0005);
        rd(2'd1, d); chk("R1 enable", d, 32'h0);
        rd(2'd2, d); chk("R1 thresh", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R3 level flags from the vector table
        foreach (VEC[i]) begin
            m_tthr = VEC[i][11:7]; m_rthr = VEC[i][6:2];
            wr(2'd2, {11'd0, m_rthr, 11'd0, m_tthr});
            tx_count = VEC[i][23:18]; rx_count = VEC[i][17:12];
            rd(2'd0, d);
            chk("R3 level vector", d, {29'd0, VEC[i][1], 1'b0, VEC[i][0]});
        end
        rd(2'd2, d); chk("R3 thresh readback", d, 32'h0014_000A);
        // R3 writes to level bits ignored
        tx_count = 10; rx_count = 20;
        wr(2'd0, 32'h0000_0005);
        rd(2'd0, d); chk("R3 level write ignored", d, 32'h0000_0005);

        // R2 enable keeps only implemented bits
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R2 enable mask", d, 32'h0000_D80F);
        wr(2'd1, 32'h0);

        m_tthr = 31; m_rthr = 31;
        wr(2'd2, 32'h001F_001F);
        tx_count = 0; rx_count = 30;

        // R6 full / overrun
        strobe(0, 0, 0, 1, 0); chk_status("R6 push at 30 no full");
        rx_count = 31;
        strobe(0, 0, 0, 1, 0); exp_sticky[3] = 1; chk_status("R6 full at 31");
        wr(2'd0, 32'h8);       exp_sticky[3] = 0;
        rx_count = 32;
        strobe(0, 0, 0, 1, 0); exp_sticky[14] = 1; chk_status("R6 overrun at 32, no full");

        // R7 underrun
        rx_count = 5;
        strobe(0, 0, 0, 0, 1); chk_status("R7 read nonempty no underrun");
        rx_count = 0;
        strobe(0, 0, 0, 0, 1); exp_sticky[15] = 1; chk_status("R7 underrun");

        // R8 tx overrun
        tx_count = 31;
        strobe(1, 0, 0, 0, 0); chk_status("R8 push at 31 no overrun");
        tx_count = 32;
        strobe(1, 0, 0, 0, 0); exp_sticky[12] = 1; chk_status("R8 overrun at 32");

        // R9 tx empty / done
        tx_count = 0;
        strobe(0, 1, 0, 0, 0); exp_sticky[1] = 1; chk_status("R9 tx empty");
        strobe(0, 0, 1, 0, 0); exp_sticky[11] = 1; chk_status("R9 done");

        // R4 selective clear
        wr(2'd0, 32'h0000_4000); exp_sticky[14] = 0; chk_status("R4 clear one flag");
        wr(2'd0, 32'h0000_0000); chk_status("R4 zero write no change");

        // R5 event beats clear in the same cycle
        @(negedge clk);
        wr_en = 1; wr_addr = 2'd0; wr_data = 32'h0000_0800 | 32'h0000_0002; xfer_done = 1;
        @(negedge clk);
        wr_en = 0; xfer_done = 0; exp_sticky[1] = 0;
        chk_status("R5 event wins");

        // R10 registered irq
        wr(2'd0, 32'hFFFF_FFFF); exp_sticky = '0;
        wr(2'd1, 32'h0000_0800);
        chk("R10 irq low no flag", {31'd0, irq}, 32'd0);
        strobe(0, 0, 1, 0, 0);
        chk("R10 irq one cycle late", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R10 irq asserted", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0000_0800);
        chk("R10 irq held one cycle after clear", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h0000_0001);
        tx_count = 31;
        @(negedge clk);
        chk("R10 irq from level", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h0);
        @(negedge clk);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule